// File: doc/BRIEF.md
# Shadow-Array Store and Recall Sequencer

This block sits between a host port and two word-wide arrays: a working SRAM that the host reads and writes, and a shadow nonvolatile array that keeps a copy of it. A STORE copies the whole SRAM image into the shadow array. A RECALL copies the shadow image back into the SRAM. Each copy moves one word per clock and walks every address from 0 to the top of the range. At the parameter default the range is small, and at the full-size setting it is 17 bits (128K words of 8 bits).

A STORE has three sources: a power-fail detect input, an active-low open-drain hardware store pin, and a strobe from the serial command decoder. A RECALL has two sources: the power-up sequence and a second command strobe. Every trigger is captured into a pending bit. When the sequencer is idle, a fixed priority order picks which pending request to serve. A request that arrives during a copy waits until that copy has finished. A STORE is skipped when the SRAM has not been written since the last copy in either direction.

The host port uses valid/ready. A request is taken on a clock edge where both `host_valid` and `host_ready` are high. Until then the host must hold the request and all of its fields steady. The read result comes back on `rsp_valid`/`rsp_data` one cycle after acceptance. It has no ready signal of its own, so the host must always be able to take it. `host_ready` stays low whenever a copy is running or about to start.

Top module: `nv_shadow_seq`

## Requirements
- R1: After reset is released, a RECALL runs with no command given. `host_ready` is low from the first cycle after reset until that RECALL has finished. Afterwards the SRAM holds the shadow array contents, and the shadow array keeps its contents across reset.
- R2: The host accepts one request per cycle in which `host_valid` and `host_ready` are both high. A write (`host_we`=1) stores `host_wdata` at `host_addr`. A read (`host_we`=0) returns that word on `rsp_data`, with `rsp_valid` high for exactly the one cycle after acceptance.
- R3: A STORE copies every SRAM word to the same address of the shadow array. For the whole STORE, `to_nv` is 1 and `hsb_n_oe` is 1, which drives the store pin low.
- R4: A one-cycle pulse on `sw_recall` starts a RECALL. The RECALL copies every shadow word into the SRAM, and `to_nv` and `hsb_n_oe` are both 0 while it runs.
- R5: A rising edge on `pwr_fail` requests a STORE.
- R6: A falling edge on `hsb_n_i` that the block did not cause itself requests a STORE.
- R7: When several requests are pending at once, they are served in this order: power-fail STORE, then pin STORE, then command STORE, then RECALL.
- R8: A request that arrives during a copy is kept pending and is served after that copy ends.
- R9: A STORE request that finds no host write since the last STORE or RECALL does not start a copy. `busy` and `done` both stay low.
- R10: `busy` is high for exactly 2^ADDR_W cycles per copy. `done` is high for one cycle, in the first cycle after `busy` falls.
- R11: While `busy` is high, `host_ready` is low. A host write presented during a copy does not change the SRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Power-loss detect; a rising edge requests a STORE |
| hsb_n_i | input | 1 | Level sensed on the open-drain store pin |
| hsb_n_oe | output | 1 | 1 pulls the store pin low (during a STORE) |
| sw_store | input | 1 | Command strobe requesting a STORE |
| sw_recall | input | 1 | Command strobe requesting a RECALL |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request can be accepted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| rsp_valid | output | 1 | Read data valid, one cycle after read accept |
| rsp_data | output | DATA_W | Read data |
| busy | output | 1 | A copy is in progress |
| to_nv | output | 1 | Copy direction: 1 = SRAM to shadow, 0 = shadow to SRAM |
| done | output | 1 | One-cycle pulse when a copy ends |

## Verification
The bench checks every address after each copy, so a walker that stops one word early or late leaves a stale word behind. It issues a STORE command and a RECALL command in the same cycle, and it issues a RECALL command during a STORE. An inverted priority order would show up as a RECALL first, and a pending bit that is not latched would lose the second operation. A STORE on a clean image must leave `busy` low; broken dirty tracking would start a copy anyway. A host write held during a copy must not land in the SRAM, and a second reset must restore the last image that was stored.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int REQ_N = 4;
  // Request slots, listed from highest priority to lowest.
  localparam int REQ_PF  = 0;
  localparam int REQ_PIN = 1;
  localparam int REQ_CMD = 2;
  localparam int REQ_RCL = 3;
  localparam logic [REQ_N-1:0] STORE_MASK = 4'b0111;
  localparam logic [REQ_N-1:0] PEND_AT_RESET = 4'b1000;

  typedef enum logic {WALK_IDLE, WALK_COPY} walk_st_t;
endpackage

// File: rtl/nvs_mem.sv
module nvs_mem #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvs_trig.sv
module nvs_trig
  import nvs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_fail,
  input  logic             hsb_n_i,
  input  logic             hsb_n_oe,
  input  logic             sw_store,
  input  logic             sw_recall,
  input  logic [REQ_N-1:0] clr,
  output logic [REQ_N-1:0] pend
);
  logic pf_q, pin_q;
  logic [REQ_N-1:0] req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q  <= 1'b0;
      pin_q <= 1'b1;
    end else begin
      pf_q  <= pwr_fail;
      pin_q <= hsb_n_i;
    end
  end

  always_comb begin
    req = '0;
    req[REQ_PF]  = pwr_fail & ~pf_q;
    req[REQ_PIN] = pin_q & ~hsb_n_i & ~hsb_n_oe;
    req[REQ_CMD] = sw_store;
    req[REQ_RCL] = sw_recall;
  end

  for (genvar i = 0; i < REQ_N; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= PEND_AT_RESET[i];
      else        pend[i] <= (pend[i] & ~clr[i]) | req[i];
    end
  end
endmodule

// File: rtl/nvs_arb.sv
module nvs_arb
  import nvs_pkg::*;
(
  input  logic [REQ_N-1:0] pend,
  input  logic             idle,
  input  logic             dirty,
  output logic [REQ_N-1:0] clr,
  output logic             start,
  output logic             start_store
);
  logic [REQ_N-1:0] pick;
  logic             found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < REQ_N; i++) begin
      if (pend[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    clr         = idle ? pick : '0;
    start_store = |(pick & STORE_MASK);
    start       = idle && found && (!start_store || dirty);
  end
endmodule

// File: rtl/nvs_walk.sv
module nvs_walk
  import nvs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_store,
  output logic          busy,
  output logic          to_nv,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam logic [AW-1:0] LAST = '1;
  walk_st_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= WALK_IDLE;
      addr  <= '0;
      to_nv <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        WALK_IDLE: if (start) begin
          st    <= WALK_COPY;
          addr  <= '0;
          to_nv <= start_store;
        end
        WALK_COPY: begin
          addr <= addr + 1'b1;
          if (addr == LAST) begin
            st   <= WALK_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= WALK_IDLE;
      endcase
    end
  end

  assign busy = (st == WALK_COPY);
endmodule

// File: rtl/nv_shadow_seq.sv
module nv_shadow_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_fail,
  input  logic              hsb_n_i,
  output logic              hsb_n_oe,
  input  logic              sw_store,
  input  logic              sw_recall,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              to_nv,
  output logic              done
);
  logic [REQ_N-1:0]  pend, clr;
  logic              start, start_store, dirty;
  logic [ADDR_W-1:0] walk_addr, sram_raddr, sram_waddr;
  logic [DATA_W-1:0] sram_rd, nv_rd, sram_wd;
  logic              sram_we, nv_we, acc, acc_wr;

  nvs_trig i_trig (
    .clk, .rst_n, .pwr_fail, .hsb_n_i, .hsb_n_oe,
    .sw_store, .sw_recall, .clr, .pend
  );

  nvs_arb i_arb (
    .pend, .idle(!busy), .dirty, .clr, .start, .start_store
  );

  nvs_walk #(.AW(ADDR_W)) i_walk (
    .clk, .rst_n, .start, .start_store,
    .busy, .to_nv, .addr(walk_addr), .done
  );

  assign host_ready = !busy && !start;
  assign acc        = host_valid && host_ready;
  assign acc_wr     = acc && host_we;
  assign hsb_n_oe   = busy && to_nv;

  assign sram_raddr = busy ? walk_addr : host_addr;
  assign sram_waddr = busy ? walk_addr : host_addr;
  assign sram_wd    = busy ? nv_rd : host_wdata;
  assign sram_we    = acc_wr || (busy && !to_nv);
  assign nv_we      = busy && to_nv;

  nvs_mem #(.AW(ADDR_W), .DW(DATA_W)) i_sram (
    .clk, .we(sram_we), .waddr(sram_waddr), .wdata(sram_wd),
    .raddr(sram_raddr), .rdata(sram_rd)
  );

  nvs_mem #(.AW(ADDR_W), .DW(DATA_W)) i_nv (
    .clk, .we(nv_we), .waddr(walk_addr), .wdata(sram_rd),
    .raddr(walk_addr), .rdata(nv_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (start)       dirty <= 1'b0;
      else if (acc_wr) dirty <= 1'b1;
      rsp_valid <= acc && !host_we;
      if (acc && !host_we) rsp_data <= sram_rd;
    end
  end
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic host_ready,
  input logic host_valid,
  input logic host_we,
  input logic rsp_valid,
  input logic to_nv,
  input logic done
);
  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !host_ready);
  a_r10_done_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(to_nv));
  a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(host_valid && host_ready && !host_we));
endmodule

bind nv_shadow_seq nvs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .host_ready(host_ready),
  .host_valid(host_valid), .host_we(host_we), .rsp_valid(rsp_valid),
  .to_nv(to_nv), .done(done)
);

// File: tb/test_nv_shadow_seq.sv
module test_nv_shadow_seq;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0, ext_pull = 1'b0, sw_store = 1'b0, sw_recall = 1'b0;
  logic host_valid = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic hsb_n_i, hsb_n_oe, host_ready, rsp_valid, busy, to_nv, done;
  logic [DW-1:0] rsp_data;

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_nv [DEPTH];

  always #10 clk = ~clk;
  assign hsb_n_i = ~(hsb_n_oe | ext_pull);

  nv_shadow_seq #(.ADDR_W(AW), .DATA_W(DW)) i_nv_shadow_seq (
    .clk, .rst_n, .pwr_fail, .hsb_n_i, .hsb_n_oe, .sw_store, .sw_recall,
    .host_valid, .host_ready, .host_we, .host_addr, .host_wdata,
    .rsp_valid, .rsp_data, .busy, .to_nv, .done
  );

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'((a * 37 + k * 11 + 5) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic host_rd(input int a, output logic [DW-1:0] d, output bit v);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b0; host_addr = AW'(a);
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    d = rsp_data; v = rsp_valid;
  endtask

  task automatic fill(input int k);
    for (int a = 0; a < DEPTH; a++) host_wr(a, pat(a, k));
  endtask

  task automatic sweep(input int k, input string req);
    int bad = 0;
    logic [DW-1:0] d;
    bit v;
    for (int a = 0; a < DEPTH; a++) begin
      host_rd(a, d, v);
      if (!v || d !== pat(a, k)) begin
        if (bad == 0) chk(1'b0, req, int'(d), int'(pat(a, k)));
        bad++;
      end
    end
    if (bad == 0) chk(1'b1, req, 0, 0);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  // Waits for a copy and checks its direction, pin, length and done pulse.
  task automatic wait_op(input bit exp_store, input bit chk_len, input string req);
    int n = 0, w = 0;
    while (!busy && w < 40) begin @(negedge clk); w++; end
    if (!busy) begin
      chk(1'b0, req, 0, 1);
      return;
    end
    chk(to_nv == exp_store, req, int'(to_nv), int'(exp_store));
    chk(hsb_n_oe == exp_store, "R3 pin", int'(hsb_n_oe), int'(exp_store));
    while (busy && n < 4 * DEPTH) begin @(negedge clk); n++; end
    if (chk_len) chk(n == DEPTH, "R10 busy length", n, DEPTH);
    chk(done == 1'b1, "R10 done at end", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(host_ready == 1'b0, "R1 not ready after reset", int'(host_ready), 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    logic [DW-1:0] d;
    bit v;
    bit saw_ready;

    // R1: power-up recall.
    do_reset();
    wait_op(1'b0, 1'b1, "R1 power-up recall");

    // R2: host write and read over all addresses.
    fill(1);
    sweep(1, "R2 host read-back");

    // R3: command store.
    pulse(sw_store);
    wait_op(1'b1, 1'b1, "R3 command store");
    for (int a = 0; a < DEPTH; a++) exp_nv[a] = pat(a, 1);

    // R4: command recall restores the stored image.
    fill(2);
    pulse(sw_recall);
    wait_op(1'b0, 1'b1, "R4 command recall");
    sweep(1, "R4 recall data");

    // R9: store on clean image is skipped.
    pulse(sw_store);
    begin
      bit seen = 1'b0;
      repeat (20) begin @(negedge clk); if (busy || done) seen = 1'b1; end
      chk(!seen, "R9 clean store skipped", int'(seen), 0);
    end

    // R5: power-fail rising edge.
    fill(3);
    @(negedge clk); pwr_fail = 1'b1;
    wait_op(1'b1, 1'b1, "R5 power-fail store");
    pwr_fail = 1'b0;
    fill(4);
    pulse(sw_recall);
    wait_op(1'b0, 1'b1, "R5 recall");
    sweep(3, "R5 stored data");

    // R6: external pin pulled low.
    fill(5);
    @(negedge clk); ext_pull = 1'b1;
    repeat (2) @(negedge clk);
    ext_pull = 1'b0;
    wait_op(1'b1, 1'b1, "R6 pin store");
    fill(6);
    pulse(sw_recall);
    wait_op(1'b0, 1'b1, "R6 recall");
    sweep(5, "R6 stored data");

    // R7: store and recall requested together; store wins.
    fill(7);
    @(negedge clk); sw_store = 1'b1; sw_recall = 1'b1;
    @(negedge clk); sw_store = 1'b0; sw_recall = 1'b0;
    wait_op(1'b1, 1'b1, "R7 store first");
    wait_op(1'b0, 1'b1, "R7 recall second");
    sweep(7, "R7 data after both");

    // R8: recall requested during a store is served afterwards.
    fill(8);
    pulse(sw_store);
    while (!busy) @(negedge clk);
    pulse(sw_recall);
    wait_op(1'b1, 1'b0, "R8 running store");
    wait_op(1'b0, 1'b1, "R8 latched recall");
    sweep(8, "R8 data");

    // R11: host write held during a copy is not accepted.
    fill(9);
    pulse(sw_store);
    while (!busy) @(negedge clk);
    host_valid = 1'b1; host_we = 1'b1; host_addr = '0; host_wdata = ~pat(0, 9);
    saw_ready = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (host_ready) saw_ready = 1'b1;
    end
    host_valid = 1'b0;
    chk(!saw_ready, "R11 ready low while busy", int'(saw_ready), 0);
    wait_op(1'b1, 1'b0, "R11 store");
    host_rd(0, d, v);
    chk(v && d == pat(0, 9), "R11 write blocked", int'(d), int'(pat(0, 9)));

    // R1: image survives reset and is recalled automatically.
    fill(10);
    do_reset();
    wait_op(1'b0, 1'b1, "R1 second power-up");
    sweep(9, "R1 recalled image");

    summary();
  end
endmodule